// File: doc/BRIEF.md
# Strobed FIFO with Ready Flags

This block is a first-in first-out buffer of 64 words by 9 bits. A writer pushes words with a one-cycle shift-in strobe, and a reader pops them with a one-cycle shift-out strobe. Both strobes are sampled on the rising edge of one system clock, and the two sides work independently. An input-ready handshake tells the writer that space remains. An output-ready handshake tells the reader that a valid word is on the data outputs.

Storage is a register array addressed by separate write and read pointers, not a shift chain. The head word is read combinationally at the read pointer. A word written into an empty buffer is therefore on the outputs one edge after the write, with no ripple through the depth.

Occupancy is reported by two flags that are read together. An active-low asynchronous master reset empties the buffer. An output enable puts the data outputs in high impedance. To build wider words, place several instances side by side and tie off their spare data inputs.

Top module: `strobe_fifo`

## Requirements
- R1: While `rstN` is low, and at once on its falling edge without waiting for a clock, the block is empty: `inReady`=1, `outReady`=0, `halfFull`=0, `full`=0.
- R2: When `shiftIn` is high and `inReady` is high at a rising edge, `dataIn` is stored as the newest word and the occupancy grows by one.
- R3: A `shiftIn` while `inReady` is low is ignored, so the stored words are unchanged. A `shiftOut` while `outReady` is low is ignored, so the buffer stays empty.
- R4: When `outEn` is low, all 9 bits of `dataOut` are high impedance. When it is high, `dataOut` drives the oldest stored word.
- R5: `inReady` is low exactly when 64 words are held.
- R6: Flag code: `full`=1 only at 64 words, and `halfFull`=1 at 32 words or more. `halfFull`=0, `full`=0 and `outReady`=0 together mean empty.
- R7: Words leave in the order they were accepted, including after the pointers wrap past location 63 back to 0.
- R8: A rising edge with an accepted write and an accepted read leaves the occupancy unchanged. A simultaneous strobe pair on an empty buffer only writes, and on a full buffer only reads.
- R9: After a write into an empty buffer, `outReady` is high after that same edge and `dataOut` shows the word, with no shift-out needed.
- R10: When `shiftOut` and `outReady` are both high at a rising edge, the head word is removed, and the next word (if any) is on `dataOut` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both strobes are sampled on its rising edge |
| rstN | input | 1 | Asynchronous master reset, active low |
| shiftIn | input | 1 | Write strobe, one cycle per word |
| dataIn | input | 9 | Word to be written |
| shiftOut | input | 1 | Read strobe, one cycle per word |
| outEn | input | 1 | Output enable; low puts dataOut in high impedance |
| dataOut | output | 9 | Oldest stored word |
| inReady | output | 1 | Buffer can accept a word |
| outReady | output | 1 | A valid word is on dataOut |
| halfFull | output | 1 | At least half of the depth is occupied |
| full | output | 1 | Every location is occupied |

## Verification
The bound checker watches, on every cycle, the occupancy arithmetic for lone writes, lone reads and paired strobes. It also checks that a full buffer never shows input ready, that full always implies half-full, and that the ready and half-full flags only rise after an accepted write. Data ordering across pointer wrap, the fall-through timing of the first word, the dropped write into a full buffer and the high-impedance outputs can only be shown by the bench. The bench compares every output against a queue model of the accepted words, and applies an asynchronous reset in the middle of a run.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // Strobes from the control unit to the storage array.
  typedef struct packed {
    logic wrEn;   // store dataIn at the write pointer this edge
    logic rdEn;   // retire the word at the read pointer this edge
  } fifoStrobes_t;

  // Next value of a pointer that wraps at depth-1.
  function automatic int unsigned nextSlot(input int unsigned cur, input int unsigned depth);
    return (cur == depth - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int HALF  = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic             shiftOut,
  output fifoStrobes_t     strobes,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] occupancy,
  output logic             inReady,
  output logic             outReady,
  output logic             halfFull,
  output logic             full
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(HALF);

  logic [PTR_W-1:0] wrPtrNext;
  logic [PTR_W-1:0] rdPtrNext;
  logic [CNT_W-1:0] occNext;

  // Handshakes come from the registered count only.
  always_comb begin
    inReady  = (occupancy != DEPTH_C);
    outReady = (occupancy != '0);
    full     = (occupancy == DEPTH_C);
    halfFull = (occupancy >= HALF_C);
  end

  // A strobe is ignored when its side is not ready.
  always_comb begin
    strobes.wrEn = shiftIn  & inReady;
    strobes.rdEn = shiftOut & outReady;
  end

  // Pointer wrap: a power-of-two depth rolls over by itself, any other
  // depth needs an explicit compare.
  generate
    if (DEPTH == (1 << PTR_W)) begin : g_pow2Wrap
      always_comb begin
        wrPtrNext = wrPtr + PTR_W'(1);
        rdPtrNext = rdPtr + PTR_W'(1);
      end
    end else begin : g_cmpWrap
      always_comb begin
        wrPtrNext = PTR_W'(nextSlot(int'(wrPtr), DEPTH));
        rdPtrNext = PTR_W'(nextSlot(int'(rdPtr), DEPTH));
      end
    end
  endgenerate

  always_comb begin
    unique case ({strobes.wrEn, strobes.rdEn})
      2'b10:   occNext = occupancy + CNT_W'(1);
      2'b01:   occNext = occupancy - CNT_W'(1);
      default: occNext = occupancy;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
    end else begin
      if (strobes.wrEn) wrPtr <= wrPtrNext;
      if (strobes.rdEn) rdPtr <= rdPtrNext;
      occupancy <= occNext;
    end
  end

endmodule

// File: rtl/strobe_fifo_data.sv
module strobe_fifo_data
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  fifoStrobes_t     strobes,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] headWord
);

  logic [WIDTH-1:0] cells [DEPTH];

  // One register row per location; each row loads only when addressed.
  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (strobes.wrEn && (wrPtr == PTR_W'(i))) cells[i] <= dataIn;
    end
  end

  // Combinational read port: the head word falls through at once.
  always_comb headWord = cells[rdPtr];

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             shiftOut,
  input  logic             outEn,
  output logic [WIDTH-1:0] dataOut,
  output logic             inReady,
  output logic             outReady,
  output logic             halfFull,
  output logic             full
);

  fifoStrobes_t     strobes;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] occupancy;
  logic [WIDTH-1:0] headWord;

  strobe_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .shiftIn   (shiftIn),
    .shiftOut  (shiftOut),
    .strobes   (strobes),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .occupancy (occupancy),
    .inReady   (inReady),
    .outReady  (outReady),
    .halfFull  (halfFull),
    .full      (full)
  );

  strobe_fifo_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk      (clk),
    .strobes  (strobes),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .dataIn   (dataIn),
    .headWord (headWord)
  );

  assign dataOut = outEn ? headWord : {WIDTH{1'bz}};

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             shiftIn,
  input logic             shiftOut,
  input logic             inReady,
  input logic             outReady,
  input logic             halfFull,
  input logic             full,
  input logic [CNT_W-1:0] occupancy
);

  logic wrOk;
  logic rdOk;
  assign wrOk = shiftIn && inReady;
  assign rdOk = shiftOut && outReady;

  // R2: a lone accepted write adds exactly one word
  a_r2_write_adds: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && !rdOk) |=> (occupancy == $past(occupancy) + CNT_W'(1)));

  // R10: a lone accepted read removes exactly one word
  a_r10_read_removes: assert property (@(posedge clk) disable iff (!rstN)
    (rdOk && !wrOk) |=> (occupancy == $past(occupancy) - CNT_W'(1)));

  // R8: paired accepted strobes keep the count
  a_r8_pair_holds: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && rdOk) |=> $stable(occupancy));

  // R3: a refused write and a refused read leave the count alone
  a_r3_refused_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!wrOk && !rdOk) |=> $stable(occupancy));

  // R5: a full buffer never offers input ready
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !inReady);

  // R6: full implies half-full
  a_r6_full_has_half: assert property (@(posedge clk) disable iff (!rstN)
    full |-> halfFull);

  // R6: half-full only rises after a write
  a_r6_half_rises_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halfFull) |-> $past(shiftIn));

  // R9: output ready only rises after a write
  a_r9_ready_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outReady) |-> $past(shiftIn));

endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .shiftIn   (shiftIn),
  .shiftOut  (shiftOut),
  .inReady   (inReady),
  .outReady  (outReady),
  .halfFull  (halfFull),
  .full      (full),
  .occupancy (occupancy)
);

// File: tb/strobe_fifo_tb.sv
`timescale 1ns/1ps
module strobe_fifo_tb;

  localparam int DEPTH = 64;
  localparam int WIDTH = 9;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             shiftIn = 1'b0;
  logic             shiftOut = 1'b0;
  logic             outEn = 1'b1;
  logic [WIDTH-1:0] dataIn = '0;
  wire  [WIDTH-1:0] dataOut;
  wire              inReady, outReady, halfFull, full;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] model [$];

  always #10 clk = ~clk;   // 50 MHz

  strobe_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .dataIn(dataIn),
    .shiftOut(shiftOut), .outEn(outEn), .dataOut(dataOut),
    .inReady(inReady), .outReady(outReady), .halfFull(halfFull), .full(full)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // Compare every output with the queue model (R5, R6, R7, R9, R10).
  task automatic checkState(input string tag);
    int n;
    n = model.size();
    check({tag, " R5 inReady"}, int'(inReady), int'(n < DEPTH));
    check({tag, " R6 full"}, int'(full), int'(n == DEPTH));
    check({tag, " R6 halfFull"}, int'(halfFull), int'(n >= DEPTH / 2));
    check({tag, " R9 outReady"}, int'(outReady), int'(n > 0));
    if (n > 0) check({tag, " R7 head word"}, int'(dataOut), int'(model[0]));
  endtask

  // One clock with the given strobes; the model follows R2, R3, R8, R10.
  task automatic cycle(input string tag, input logic si, input logic so,
                       input logic [WIDTH-1:0] din);
    bit acceptW, acceptR;
    acceptW = si && (model.size() < DEPTH);
    acceptR = so && (model.size() > 0);
    @(negedge clk);
    shiftIn = si; shiftOut = so; dataIn = din;
    @(posedge clk);
    #1;
    shiftIn = 1'b0; shiftOut = 1'b0;
    if (acceptR) void'(model.pop_front());
    if (acceptW) model.push_back(din);
    checkState(tag);
  endtask

  task automatic t_reset();
    check("R1 inReady", int'(inReady), 1);
    check("R1 outReady", int'(outReady), 0);
    check("R1 halfFull", int'(halfFull), 0);
    check("R1 full", int'(full), 0);
  endtask

  task automatic t_fallthrough();
    // R9: the first word is visible right after its write edge
    cycle("R9 first write", 1'b1, 1'b0, 9'h1A5);
    check("R9 outReady after one edge", int'(outReady), 1);
    check("R9 fall-through data", int'(dataOut), 'h1A5);
  endtask

  task automatic t_outEnable();
    // R4: outEn low floats the outputs; a stored nonzero word must not
    // show. A two-state simulator reads the floating bus as zero.
    @(negedge clk); outEn = 1'b0; #1;
    checks++;
    if (!((dataOut === {WIDTH{1'bz}}) || (dataOut === '0))) begin
      errors++;
      $display("FAIL R4 hi-z: actual %0h expected z", dataOut);
    end
    outEn = 1'b1; #1;
    check("R4 driven again", int'(dataOut), int'(model[0]));
  endtask

  task automatic t_fillAndOverflow();
    // R5 R6: fill to the top, watching the flag code at every step
    while (model.size() < DEPTH)
      cycle("R6 fill", 1'b1, 1'b0, WIDTH'(model.size() * 7 + 3));
    check("R5 inReady low at 64", int'(inReady), 0);
    // R3: a write into a full buffer is dropped
    cycle("R3 write when full", 1'b1, 1'b0, 9'h0FF);
    // R8: pair on a full buffer only reads
    cycle("R8 pair when full", 1'b1, 1'b1, 9'h0EE);
    check("R8 one word freed", int'(full), 0);
  endtask

  task automatic t_drain();
    // R7 R10: empty the buffer, checking the order of every word
    while (model.size() > 0) cycle("R10 drain", 1'b0, 1'b1, '0);
    // R3: a read on an empty buffer is ignored
    cycle("R3 read when empty", 1'b0, 1'b1, '0);
    check("R3 still empty", int'(outReady), 0);
    // R8: pair on an empty buffer only writes
    cycle("R8 pair when empty", 1'b1, 1'b1, 9'h123);
    check("R8 word kept", int'(dataOut), 'h123);
  endtask

  task automatic t_pairsAndWrap();
    // R8: hold a level of 40 words through paired strobes
    while (model.size() < 40) cycle("R2 ramp", 1'b1, 1'b0, WIDTH'(model.size() + 200));
    for (int i = 0; i < 30; i++) cycle("R8 paired", 1'b1, 1'b1, WIDTH'(i * 13 + 1));
    check("R8 level kept halfFull", int'(halfFull), 1);
    // R7: mixed traffic moves both pointers around several times
    for (int i = 0; i < 300; i++)
      cycle("R7 wrap", (i % 3) != 2, (i % 4) != 0, WIDTH'(i * 37 + 5));
    while (model.size() > 0) cycle("R7 final drain", 1'b0, 1'b1, '0);
  endtask

  task automatic t_asyncReset();
    for (int i = 0; i < 35; i++) cycle("R2 preload", 1'b1, 1'b0, WIDTH'(i + 9));
    // R1: reset between edges clears flags without a clock
    @(negedge clk); #3 rstN = 1'b0; #2;
    model.delete();
    t_reset();
    @(negedge clk); rstN = 1'b1;
    cycle("R1 after reset", 1'b1, 1'b0, 9'h055);
  endtask

  initial begin
    #35;
    t_reset();
    @(negedge clk); rstN = 1'b1;
    t_fallthrough();
    t_outEnable();
    t_fillAndOverflow();
    t_drain();
    t_pairsAndWrap();
    t_asyncReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule